// File: doc/BRIEF.md
# Vacuous Opcode Instruction Injector

This block sits on the instruction fetch path of a small 4-bit processor, between the program memory image and the data pins the processor reads. A separate watcher reports each executed instruction as an event that carries its program counter and its 12-bit code. One code pattern is a do-nothing self-copy: the leading nibble is zero and both register nibbles are equal. When such an event arrives, the block takes the repeated nibble `x`, squares it into an 8-bit value and starts an injection.

While the injection runs, the nibbles fetched from the three program addresses after the trigger are replaced by a generated sequence. The first two are move-immediate instructions that place the high and low result nibbles into registers E and F. The third is a jump back to the first generated instruction's address. The processor has no other path by which an outside agent can write its register file, so this is how the result reaches it.

Each instruction occupies three nibble locations. For program address `p`, the leading nibble is at `p`, the middle nibble at `p | 0x200` and the trailing nibble at `p | 0x100`. Once the trailing nibble of the jump has been read, the block returns memory contents again at every address.

Top module: `opcode_injector`

## Requirements
- R1: When no injection is active, `out_nibble` equals `mem_nibble` for every read address; this includes the state right after reset.
- R2: An event with `trig_op[11:8]==0` and `trig_op[7:4]==trig_op[3:0]` starts an injection at the next clock edge, with base address `trig_pc`. Any other code, including a nonzero leading nibble or two unequal register nibbles, leaves the output unchanged.
- R3: The injected result is `x*x` as 8 bits, where `x` is `trig_op[3:0]` of the starting event.
- R4: At base+1, position bits `rd_addr[9:8]` of 00, 10 and 01 return 0x1, the high result nibble and 0xE.
- R5: At base+2, those positions return 0x1, the low result nibble and 0xF (for x=3 the two instructions read 10E and 19F).
- R6: At base+3, those positions return the jump nibble (default 0xC), then bits 7..4 and bits 3..0 of base+1.
- R7: During an injection, position 11 and every program address other than base+1..base+3 (the base itself included) return `mem_nibble`.
- R8: A clock edge with `rd_strobe` high and `rd_addr` on the trailing nibble (bits 9..8 = 01) of base+3 ends the injection. Strobed reads of the other two nibbles of base+3 do not end it.
- R9: A trigger event that arrives while an injection is active is ignored; the base and the result are kept.
- R10: Program addresses wrap modulo 256, so base 0xFE injects at 0xFF, 0x00 and 0x01, and the jump targets 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| trig_valid | input | 1 | Executed-instruction event strobe |
| trig_pc | input | 8 | Program address of the reported instruction |
| trig_op | input | 12 | 12-bit code of the reported instruction |
| rd_addr | input | 10 | Fetch address: bits 9..8 nibble position, bits 7..0 program address |
| rd_strobe | input | 1 | Marks the clock edge at which the current read completes |
| mem_nibble | input | 4 | Nibble read from the program memory image |
| out_nibble | output | 4 | Nibble driven to the processor |

## Verification
On every cycle the assertions check several properties. Outside an injection, and at the spare position, the output passes through unchanged. A qualifying event captures its base and the square of its operand. An active injection holds its state until the trailing jump nibble is read with the strobe, and then it ends. The exact instruction nibbles at each offset and position, the rejection of non-qualifying codes, the wrap at address 0xFF and the return to memory contents after the jump can only be shown by the bench. Its sweep covers all sixteen operands, many base addresses and every nibble position.

// File: rtl/inj_pkg.sv
package inj_pkg;

  // Nibble position encoded in the two address bits above the program address.
  typedef enum logic [1:0] {
    POS_LEAD  = 2'b00,
    POS_TAIL  = 2'b01,
    POS_MID   = 2'b10,
    POS_SPARE = 2'b11
  } nib_pos_e;

endpackage

// File: rtl/inj_trigger.sv
module inj_trigger #(
  parameter int NIB_W = 4
) (
  input  logic               trig_valid,
  input  logic [3*NIB_W-1:0] trig_op,
  input  logic               busy,
  output logic               fire,
  output logic [NIB_W-1:0]   operand
);

  logic [NIB_W-1:0] op_lead;
  logic [NIB_W-1:0] op_mid;
  logic [NIB_W-1:0] op_tail;
  logic             self_copy;

  always_comb begin
    op_lead   = trig_op[3*NIB_W-1 -: NIB_W];
    op_mid    = trig_op[2*NIB_W-1 -: NIB_W];
    op_tail   = trig_op[NIB_W-1:0];
    self_copy = (op_lead == '0) && (op_mid == op_tail);
    fire      = trig_valid && self_copy && !busy;
    operand   = op_tail;
  end

endmodule

// File: rtl/inj_square.sv
module inj_square #(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W-1:0]   operand,
  output logic [2*NIB_W-1:0] square
);

  localparam int RES_W = 2 * NIB_W;

  logic [RES_W-1:0] widened;
  logic [RES_W-1:0] partial [NIB_W];
  logic [RES_W-1:0] acc     [NIB_W+1];

  assign widened = {{NIB_W{1'b0}}, operand};
  assign acc[0]  = '0;

  // Shift-and-add multiplier, one row per operand bit.
  for (genvar i = 0; i < NIB_W; i++) begin : g_row
    assign partial[i] = operand[i] ? (widened << i) : '0;
    assign acc[i+1]   = acc[i] + partial[i];
  end

  assign square = acc[NIB_W];

endmodule

// File: rtl/inj_seq.sv
module inj_seq
  import inj_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [2*NIB_W-1:0] trig_pc,
  input  logic [2*NIB_W-1:0] square,
  input  logic               rd_strobe,
  input  logic [2*NIB_W+1:0] rd_addr,
  output logic               active,
  output logic [2*NIB_W-1:0] base,
  output logic [2*NIB_W-1:0] result
);

  localparam int PA_W = 2 * NIB_W;

  logic             active_nxt;
  logic [PA_W-1:0]  base_nxt;
  logic [PA_W-1:0]  result_nxt;
  logic             load_en;
  logic             end_hit;
  logic [PA_W-1:0]  jump_addr;
  nib_pos_e         rd_pos;

  always_comb begin
    rd_pos    = nib_pos_e'(rd_addr[PA_W+1:PA_W]);
    jump_addr = base + PA_W'(3);
    end_hit   = active && rd_strobe && (rd_pos == POS_TAIL)
                && (rd_addr[PA_W-1:0] == jump_addr);
    load_en   = fire;
  end

  always_comb begin
    active_nxt = active;
    base_nxt   = base;
    result_nxt = result;
    if (load_en) begin
      active_nxt = 1'b1;
      base_nxt   = trig_pc;
      result_nxt = square;
    end else if (end_hit) begin
      active_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      result <= '0;
    end else begin
      active <= active_nxt;
      if (load_en) begin
        base   <= base_nxt;
        result <= result_nxt;
      end
    end
  end

  assert_fire_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (active && base == $past(trig_pc)));

  assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !end_hit) |=> (active && $stable(base) && $stable(result)));

  assert_jump_read_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    end_hit |=> !active);

endmodule

// File: rtl/inj_mux.sv
module inj_mux
  import inj_pkg::*;
#(
  parameter int NIB_W    = 4,
  parameter int MOVI_NIB = 1,
  parameter int JMP_NIB  = 12,
  parameter int REG_HI   = 14,
  parameter int REG_LO   = 15
) (
  input  logic               active,
  input  logic [2*NIB_W-1:0] base,
  input  logic [2*NIB_W-1:0] result,
  input  logic [2*NIB_W+1:0] rd_addr,
  input  logic [NIB_W-1:0]   mem_nibble,
  output logic [NIB_W-1:0]   out_nibble
);

  localparam int PA_W = 2 * NIB_W;
  localparam logic [NIB_W-1:0] MOVI_C = NIB_W'(MOVI_NIB);
  localparam logic [NIB_W-1:0] JMP_C  = NIB_W'(JMP_NIB);
  localparam logic [NIB_W-1:0] HI_C   = NIB_W'(REG_HI);
  localparam logic [NIB_W-1:0] LO_C   = NIB_W'(REG_LO);

  logic [PA_W-1:0]  offset;
  logic [PA_W-1:0]  target;
  logic [NIB_W-1:0] w_lead;
  logic [NIB_W-1:0] w_mid;
  logic [NIB_W-1:0] w_tail;
  logic             slot_hit;
  nib_pos_e         rd_pos;

  // Generated instruction for the addressed slot.
  always_comb begin
    offset   = rd_addr[PA_W-1:0] - base;
    target   = base + PA_W'(1);
    slot_hit = 1'b0;
    w_lead   = '0;
    w_mid    = '0;
    w_tail   = '0;
    if (active) begin
      case (offset)
        PA_W'(1): begin
          slot_hit = 1'b1;
          w_lead   = MOVI_C;
          w_mid    = result[PA_W-1 -: NIB_W];
          w_tail   = HI_C;
        end
        PA_W'(2): begin
          slot_hit = 1'b1;
          w_lead   = MOVI_C;
          w_mid    = result[NIB_W-1:0];
          w_tail   = LO_C;
        end
        PA_W'(3): begin
          slot_hit = 1'b1;
          w_lead   = JMP_C;
          w_mid    = target[PA_W-1 -: NIB_W];
          w_tail   = target[NIB_W-1:0];
        end
        default: slot_hit = 1'b0;
      endcase
    end
  end

  // Position select, falling back to memory contents.
  always_comb begin
    rd_pos     = nib_pos_e'(rd_addr[PA_W+1:PA_W]);
    out_nibble = mem_nibble;
    if (slot_hit) begin
      case (rd_pos)
        POS_LEAD:  out_nibble = w_lead;
        POS_MID:   out_nibble = w_mid;
        POS_TAIL:  out_nibble = w_tail;
        default:   out_nibble = mem_nibble;
      endcase
    end
  end

endmodule

// File: rtl/opcode_injector.sv
module opcode_injector #(
  parameter int NIB_W    = 4,
  parameter int MOVI_NIB = 1,
  parameter int JMP_NIB  = 12,
  parameter int REG_HI   = 14,
  parameter int REG_LO   = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_valid,
  input  logic [2*NIB_W-1:0] trig_pc,
  input  logic [3*NIB_W-1:0] trig_op,
  input  logic [2*NIB_W+1:0] rd_addr,
  input  logic               rd_strobe,
  input  logic [NIB_W-1:0]   mem_nibble,
  output logic [NIB_W-1:0]   out_nibble
);

  localparam int PA_W = 2 * NIB_W;

  logic             rst_meta_n;
  logic             rst_sync_n;
  logic             fire;
  logic [NIB_W-1:0] operand;
  logic [PA_W-1:0]  square;
  logic             active;
  logic [PA_W-1:0]  base;
  logic [PA_W-1:0]  result;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  inj_trigger #(.NIB_W(NIB_W)) u_trigger (
    .trig_valid (trig_valid),
    .trig_op    (trig_op),
    .busy       (active),
    .fire       (fire),
    .operand    (operand)
  );

  inj_square #(.NIB_W(NIB_W)) u_square (
    .operand (operand),
    .square  (square)
  );

  inj_seq #(.NIB_W(NIB_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .fire      (fire),
    .trig_pc   (trig_pc),
    .square    (square),
    .rd_strobe (rd_strobe),
    .rd_addr   (rd_addr),
    .active    (active),
    .base      (base),
    .result    (result)
  );

  inj_mux #(
    .NIB_W    (NIB_W),
    .MOVI_NIB (MOVI_NIB),
    .JMP_NIB  (JMP_NIB),
    .REG_HI   (REG_HI),
    .REG_LO   (REG_LO)
  ) u_mux (
    .active     (active),
    .base       (base),
    .result     (result),
    .rd_addr    (rd_addr),
    .mem_nibble (mem_nibble),
    .out_nibble (out_nibble)
  );

  assert_idle_passthrough_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !active |-> (out_nibble == mem_nibble));

  assert_spare_position_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_addr[PA_W+1:PA_W] == 2'b11) |-> (out_nibble == mem_nibble));

  assert_square_capture_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fire |=> (result == PA_W'($past(trig_op[NIB_W-1:0]) * $past(trig_op[NIB_W-1:0]))));

endmodule

// File: tb/test_opcode_injector.sv
`timescale 1ns/1ps
module test_opcode_injector;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       trig_valid;
  logic [7:0] trig_pc;
  logic [11:0] trig_op;
  logic [9:0] rd_addr;
  logic       rd_strobe;
  logic [3:0] mem_nibble;
  logic [3:0] out_nibble;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  function automatic logic [3:0] mem_of(logic [9:0] a);
    return a[3:0] ^ a[7:4] ^ {a[9:8], a[9:8]} ^ 4'h5;
  endfunction

  assign mem_nibble = mem_of(rd_addr);

  opcode_injector i_opcode_injector (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_valid (trig_valid),
    .trig_pc    (trig_pc),
    .trig_op    (trig_op),
    .rd_addr    (rd_addr),
    .rd_strobe  (rd_strobe),
    .mem_nibble (mem_nibble),
    .out_nibble (out_nibble)
  );

  function automatic logic [3:0] model(bit act, logic [7:0] b, logic [3:0] x, logic [9:0] a);
    logic [7:0]  off;
    logic [7:0]  sq;
    logic [7:0]  tg;
    logic [11:0] w;
    off = a[7:0] - b;
    sq  = 8'(x * x);
    tg  = b + 8'd1;
    if (!act || a[9:8] == 2'b11) return mem_of(a);
    case (off)
      8'd1:    w = {4'h1, sq[7:4], 4'hE};
      8'd2:    w = {4'h1, sq[3:0], 4'hF};
      8'd3:    w = {4'hC, tg[7:4], tg[3:0]};
      default: return mem_of(a);
    endcase
    case (a[9:8])
      2'b00:   return w[11:8];
      2'b10:   return w[7:4];
      default: return w[3:0];
    endcase
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, rd_addr, act, exp);
    end
  endtask

  task automatic probe(string tag, bit act, logic [7:0] b, logic [3:0] x, logic [9:0] a);
    rd_addr = a;
    #1;
    check(tag, out_nibble, model(act, b, x, a));
  endtask

  task automatic pulse_trig(logic [7:0] pc, logic [11:0] op);
    @(negedge clk);
    trig_valid = 1'b1;
    trig_pc    = pc;
    trig_op    = op;
    @(negedge clk);
    trig_valid = 1'b0;
  endtask

  task automatic strobe_read(logic [9:0] a);
    @(negedge clk);
    rd_addr   = a;
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic sweep(string tag, bit act, logic [7:0] b, logic [3:0] x);
    for (int o = 0; o < 5; o++) begin
      for (int p = 0; p < 4; p++) begin
        probe(tag, act, b, x, {2'(p), 8'(b + 8'(o))});
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; trig_valid = 1'b0; trig_pc = '0; trig_op = '0;
    rd_addr = '0; rd_strobe = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state passes memory through everywhere sampled
    for (int a = 0; a < 1024; a += 37) probe("R1_reset", 1'b0, 8'd0, 4'd0, 10'(a));

    // R2..R8, R10: every operand, various bases including wrap
    for (int x = 0; x < 16; x++) begin
      logic [7:0] b;
      b = (x == 15) ? 8'hFE : (x == 14) ? 8'hFF : 8'(x * 19 + 3);
      pulse_trig(b, {4'h0, 4'(x), 4'(x)});
      sweep("R2_R3_R4_R5_R6_R7_R10", 1'b1, b, 4'(x));
      // R8: lead and mid reads of the jump do not end it
      strobe_read({2'b00, 8'(b + 8'd3)});
      strobe_read({2'b10, 8'(b + 8'd3)});
      probe("R8_not_ended", 1'b1, b, 4'(x), {2'b00, 8'(b + 8'd1)});
      // R9: a second trigger is ignored
      pulse_trig(8'(b + 8'd40), {4'h0, 4'(x ^ 5), 4'(x ^ 5)});
      sweep("R9_ignored", 1'b1, b, 4'(x));
      // R8: tail of jump ends the injection
      strobe_read({2'b01, 8'(b + 8'd3)});
      sweep("R8_ended", 1'b0, b, 4'(x));
    end

    // R10 explicit: base FE, jump at 01 targets FF
    pulse_trig(8'hFE, 12'h033);
    probe("R10_wrap_tgt_hi", 1'b1, 8'hFE, 4'd3, {2'b10, 8'h01});
    check("R10_value", out_nibble, 4'hF);
    probe("R5_10E", 1'b1, 8'hFE, 4'd3, {2'b01, 8'hFF});
    check("R4_E", out_nibble, 4'hE);
    probe("R5_19F", 1'b1, 8'hFE, 4'd3, {2'b10, 8'h00});
    check("R5_9", out_nibble, 4'h9);
    strobe_read({2'b01, 8'h01});

    // R2: non-qualifying codes leave the output alone
    for (int n = 1; n < 16; n++) begin
      pulse_trig(8'h20, {4'(n), 4'h7, 4'h7});
      sweep("R2_lead_nonzero", 1'b0, 8'h20, 4'd7);
    end
    for (int a = 0; a < 16; a++) begin
      pulse_trig(8'h50, {4'h0, 4'(a), 4'(a + 1)});
      sweep("R2_unequal", 1'b0, 8'h50, 4'(a));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule